// File: doc/BRIEF.md
# Line Clamp Window Generator

This block produces, once per video line, a clamp window and a one-cycle measurement marker, both timed on the pixel clock. It watches the horizontal sync input and treats the end of the sync pulse (the trailing edge) as the reference point of the line. From there it counts pixels. When the count reaches a programmed 14-bit start position, it raises the measurement marker for one cycle. In AC-coupled operation it also drives the clamp window high for a programmed number of pixels.

The start position reaches the block as two fields, an upper part and a lower part. The block captures the start position, the width and the coupling mode only at a trailing edge, so each line uses a single consistent set of values. A new trailing edge restarts the count and closes any window that is still open. A zero width turns the clamp off completely. The measurement marker runs in both coupling modes and drives the black-level measurement logic downstream.

Top module: `clamp_window_gen`

## Requirements
- R1: While reset is held, and until the first trailing edge of sync after reset, both `clamp_out` and `meas_strobe` stay low.
- R2: A trailing edge is sync sampled active and then inactive on two consecutive rising edges. Call the rising edge that first samples it inactive edge 0. The start value S is {`start_hi`, `start_lo`}, with `start_hi` as bits 13:8. `meas_strobe` is high for exactly one cycle, just after rising edge S+2.
- R3: With `ac_coupled` set and width W > 0, `clamp_out` is high just after rising edges S+2 through S+W+1, which is exactly W cycles. It rises in the same cycle as `meas_strobe`.
- R4: A width of zero keeps `clamp_out` low for the whole line. `meas_strobe` still pulses as in R2.
- R5: With `ac_coupled` clear, `clamp_out` stays low for the whole line. `meas_strobe` still pulses as in R2.
- R6: A new trailing edge ends an open window. `clamp_out` is low just after rising edge 1 of the new line.
- R7: The start, width and mode inputs are captured only in the cycle after edge 0. Changes at any other time have no effect on the line in progress.
- R8: If the next trailing edge arrives before rising edge S+2 of a line, that line produces neither a strobe nor a clamp.
- R9: The pixel count saturates at 16383 and does not wrap. Each line gives at most one strobe, including S = 16383 on a line longer than 16385 pixels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_pix | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsync_in | input | 1 | Horizontal sync, active level set by parameter |
| start_hi | input | 6 | Start position, bits 13:8 |
| start_lo | input | 8 | Start position, bits 7:0 |
| clamp_width | input | 8 | Clamp window length in pixels |
| ac_coupled | input | 1 | Enables the clamp output |
| clamp_out | output | 1 | Clamp window |
| meas_strobe | output | 1 | One-cycle black-level measurement marker |

## Verification
The checker watches several behaviours on every cycle:
- the outputs stay silent before the first line;
- the strobe lasts a single cycle;
- a window always opens together with the strobe;
- a trailing edge always closes the window;
- a zero width or a cleared mode keeps the clamp low;
- the captured configuration never changes between edges.

The exact position of the window relative to the trailing edge, its length in pixels, and the split of the start value across the two input fields can only be shown by the bench's line scenarios. The same holds for lines too short to reach the start, and for saturation on very long lines.

// File: rtl/cw_pkg.sv
package cw_pkg;
  parameter int unsigned START_W   = 14;
  parameter int unsigned HI_W      = 6;
  parameter int unsigned WIDTH_W   = 8;
  parameter int unsigned START_DEF = 2;
  parameter int unsigned WIDTH_DEF = 16;

  typedef struct packed {
    logic [START_W-1:0] start;
    logic [WIDTH_W-1:0] width;
    logic               ac_en;
  } line_cfg_t;
endpackage

// File: rtl/cw_rst_sync.sv
module cw_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= sync_d;
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/cw_hsync_edge.sv
module cw_hsync_edge #(
  parameter bit ACT_HIGH = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hsync_in,
  output logic trail_pulse
);
  logic       hs_lvl;
  logic [1:0] smp_q;
  logic [1:0] smp_d;

  generate
    if (ACT_HIGH) begin : g_pos
      assign hs_lvl = hsync_in;
    end else begin : g_neg
      assign hs_lvl = ~hsync_in;
    end
  endgenerate

  always_comb begin
    smp_d = {smp_q[0], hs_lvl};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) smp_q <= '0;
    else        smp_q <= smp_d;
  end

  assign trail_pulse = smp_q[1] & ~smp_q[0];
endmodule

// File: rtl/cw_line_cfg.sv
module cw_line_cfg
  import cw_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               capture,
  input  logic [START_W-1:0] start_in,
  input  logic [WIDTH_W-1:0] width_in,
  input  logic               ac_in,
  output line_cfg_t          cfg_q
);
  line_cfg_t cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (capture) begin
      cfg_d.start = start_in;
      cfg_d.width = width_in;
      cfg_d.ac_en = ac_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q.start <= START_W'(START_DEF);
      cfg_q.width <= WIDTH_W'(WIDTH_DEF);
      cfg_q.ac_en <= 1'b0;
    end else begin
      cfg_q <= cfg_d;
    end
  end
endmodule

// File: rtl/cw_pixel_count.sv
module cw_pixel_count
  import cw_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               restart,
  input  logic [START_W-1:0] start_pos,
  output logic               hit,
  output logic               line_act
);
  localparam logic [START_W-1:0] CNT_MAX = {START_W{1'b1}};

  logic [START_W-1:0] cnt_q, cnt_d;
  logic               sat_q, sat_d;
  logic               act_q, act_d;

  always_comb begin
    cnt_d = cnt_q;
    sat_d = sat_q;
    act_d = act_q;
    if (restart) begin
      cnt_d = '0;
      sat_d = 1'b0;
      act_d = 1'b1;
    end else if (act_q) begin
      if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
      else                  sat_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sat_q <= 1'b0;
      act_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      sat_q <= sat_d;
      act_q <= act_d;
    end
  end

  assign hit      = act_q & ~sat_q & ~restart & (cnt_q == start_pos);
  assign line_act = act_q;
endmodule

// File: rtl/cw_pulse_shaper.sv
module cw_pulse_shaper
  import cw_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cut,
  input  logic               hit,
  input  logic [WIDTH_W-1:0] width,
  input  logic               ac_en,
  output logic               clamp,
  output logic               strobe
);
  logic [WIDTH_W-1:0] rem_q, rem_d;
  logic               stb_q, stb_d;

  always_comb begin
    rem_d = rem_q;
    stb_d = hit;
    if (cut)                         rem_d = '0;
    else if (hit && (width != '0))   rem_d = width;
    else if (rem_q != '0)            rem_d = rem_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      stb_q <= 1'b0;
    end else begin
      rem_q <= rem_d;
      stb_q <= stb_d;
    end
  end

  assign clamp  = (rem_q != '0) & ac_en;
  assign strobe = stb_q;
endmodule

// File: rtl/clamp_window_gen.sv
module clamp_window_gen
  import cw_pkg::*;
#(
  parameter bit          HS_ACT_HIGH = 1'b1,
  parameter int unsigned RST_STAGES  = 2
) (
  input  logic                       clk_pix,
  input  logic                       rst_n,
  input  logic                       hsync_in,
  input  logic [HI_W-1:0]            start_hi,
  input  logic [START_W-HI_W-1:0]    start_lo,
  input  logic [WIDTH_W-1:0]         clamp_width,
  input  logic                       ac_coupled,
  output logic                       clamp_out,
  output logic                       meas_strobe
);
  logic               rst_sync_n;
  logic               hs_fall;
  logic [START_W-1:0] start_all;
  line_cfg_t          line_cfg;
  logic               pos_hit;
  logic               line_act;

  assign start_all = {start_hi, start_lo};

  cw_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk_pix), .rst_n_in(rst_n), .rst_n_out(rst_sync_n)
  );

  cw_hsync_edge #(.ACT_HIGH(HS_ACT_HIGH)) u_edge (
    .clk(clk_pix), .rst_n(rst_sync_n), .hsync_in(hsync_in), .trail_pulse(hs_fall)
  );

  cw_line_cfg u_cfg (
    .clk(clk_pix), .rst_n(rst_sync_n), .capture(hs_fall),
    .start_in(start_all), .width_in(clamp_width), .ac_in(ac_coupled),
    .cfg_q(line_cfg)
  );

  cw_pixel_count u_cnt (
    .clk(clk_pix), .rst_n(rst_sync_n), .restart(hs_fall),
    .start_pos(line_cfg.start), .hit(pos_hit), .line_act(line_act)
  );

  cw_pulse_shaper u_shp (
    .clk(clk_pix), .rst_n(rst_sync_n), .cut(hs_fall), .hit(pos_hit),
    .width(line_cfg.width), .ac_en(line_cfg.ac_en),
    .clamp(clamp_out), .strobe(meas_strobe)
  );
endmodule

// File: rtl/cw_checker.sv
module cw_checker
  import cw_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               hs_fall,
  input logic               line_act,
  input logic [START_W-1:0] cfg_start,
  input logic [WIDTH_W-1:0] cfg_width,
  input logic               cfg_ac,
  input logic               clamp_out,
  input logic               meas_strobe
);
  // R1
  p_quiet_before_line_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !line_act |-> (!clamp_out && !meas_strobe));
  // R2
  p_strobe_one_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    meas_strobe |=> !meas_strobe);
  // R3
  p_window_opens_with_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clamp_out) |-> meas_strobe);
  // R4
  p_zero_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_width == '0) |-> !clamp_out);
  // R5
  p_dc_mode_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_ac |-> !clamp_out);
  // R6
  p_cut_at_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hs_fall |=> !clamp_out);
  // R7
  p_cfg_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !hs_fall |=> ($stable(cfg_start) && $stable(cfg_width) && $stable(cfg_ac)));
endmodule

bind clamp_window_gen cw_checker u_chk (
  .clk(clk_pix), .rst_n(rst_sync_n), .hs_fall(hs_fall), .line_act(line_act),
  .cfg_start(line_cfg.start), .cfg_width(line_cfg.width), .cfg_ac(line_cfg.ac_en),
  .clamp_out(clamp_out), .meas_strobe(meas_strobe)
);

// File: tb/clamp_window_gen_tb_top.sv
`timescale 1ns/1ps
module clamp_window_gen_tb_top;
  logic       clk_pix = 1'b0;
  logic       rst_n;
  logic       hsync_in;
  logic [5:0] start_hi;
  logic [7:0] start_lo;
  logic [7:0] clamp_width;
  logic       ac_coupled;
  logic       clamp_out;
  logic       meas_strobe;

  always #2.5 clk_pix = ~clk_pix;

  clamp_window_gen dut_i (
    .clk_pix(clk_pix), .rst_n(rst_n), .hsync_in(hsync_in),
    .start_hi(start_hi), .start_lo(start_lo), .clamp_width(clamp_width),
    .ac_coupled(ac_coupled), .clamp_out(clamp_out), .meas_strobe(meas_strobe)
  );

  typedef struct {
    bit    clamp;
    bit    strobe;
    string tag;
  } exp_t;

  exp_t sb_q[$];
  int   total = 0;
  int   bad   = 0;
  int   p_s = 0, p_w = 0, p_len = 0;
  bit   p_ac = 1'b0;

  task automatic check_bit(bit act, bit exp, string tag, string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic void model(int s, int w, bit ac, int n, output bit cl, output bit st);
    cl = ac && (w > 0) && (n >= s + 2) && (n <= s + w + 1);
    st = (n == s + 2);
  endfunction

  // monitor: pops one expected item per cycle, samples away from the edge
  initial begin
    forever begin
      @(posedge clk_pix);
      #2;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        check_bit(clamp_out, e.clamp, e.tag, "clamp_out");
        check_bit(meas_strobe, e.strobe, e.tag, "meas_strobe");
      end
    end
  end

  task automatic idle_high(int n, string tag);
    for (int i = 0; i < n; i++) begin
      exp_t e;
      @(negedge clk_pix);
      hsync_in = 1'b1;
      e.clamp = 1'b0; e.strobe = 1'b0; e.tag = tag;
      sb_q.push_back(e);
    end
  endtask

  task automatic run_line(int s, int w, bit ac, int len, bit scramble, string tag);
    for (int c = 0; c < len; c++) begin
      exp_t e;
      bit cl, st;
      @(negedge clk_pix);
      if (c == 0) begin
        start_hi    = s[13:8];
        start_lo    = s[7:0];
        clamp_width = w[7:0];
        ac_coupled  = ac;
      end
      if (scramble && c == 3) begin
        start_hi    = 6'd0;
        start_lo    = 8'd0;
        clamp_width = 8'hFF;
        ac_coupled  = ~ac;
      end
      hsync_in = (c >= len - 6);
      if (c == 0) model(p_s, p_w, p_ac, p_len, cl, st);
      else        model(s, w, ac, c, cl, st);
      e.clamp = cl; e.strobe = st; e.tag = tag;
      sb_q.push_back(e);
    end
    p_s = s; p_w = w; p_ac = ac; p_len = len;
  endtask

  initial begin
    fork
      begin
        rst_n = 1'b0; hsync_in = 1'b1; start_hi = '0; start_lo = 8'd2;
        clamp_width = 8'd16; ac_coupled = 1'b1;
        repeat (4) @(negedge clk_pix);
        check_bit(clamp_out, 1'b0, "R1", "clamp_out in reset");
        check_bit(meas_strobe, 1'b0, "R1", "meas_strobe in reset");
        rst_n = 1'b1;
        idle_high(8, "R1");
        run_line(2, 16, 1'b1, 40, 1'b0, "R2");
        run_line(259, 2, 1'b1, 300, 1'b0, "R2");
        run_line(10, 1, 1'b1, 30, 1'b0, "R3");
        run_line(4, 7, 1'b1, 30, 1'b0, "R3");
        run_line(4, 0, 1'b1, 30, 1'b0, "R4");
        run_line(3, 5, 1'b0, 30, 1'b0, "R5");
        run_line(5, 100, 1'b1, 30, 1'b0, "R6");
        run_line(5, 3, 1'b1, 30, 1'b0, "R6");
        run_line(6, 4, 1'b1, 30, 1'b1, "R7");
        run_line(7, 5, 1'b0, 30, 1'b1, "R7");
        run_line(50, 4, 1'b1, 30, 1'b0, "R8");
        run_line(28, 6, 1'b1, 30, 1'b0, "R8");
        run_line(29, 6, 1'b1, 30, 1'b0, "R8");
        run_line(16383, 3, 1'b1, 16400, 1'b0, "R9");
        run_line(5, 2, 1'b1, 16400, 1'b0, "R9");
        run_line(2, 1, 1'b1, 12, 1'b0, "R3");
        repeat (4) @(negedge clk_pix);
      end
      begin
        repeat (200000) @(posedge clk_pix);
        total++;
        bad++;
        $display("FAIL watchdog run did not finish actual=hung expected=done");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule